// File: doc/BRIEF.md
# Receive FIFO Error Status Tracker

This block is the receive-side bookkeeping of a serial channel. A receiver pushes each assembled character together with three per-character error flags: line break, framing error and parity error. The block stores the character and its flags as one FIFO entry. The host pops characters from the head. Through the same block it reads an 8-bit channel status word, which merges the head-of-FIFO error flags with live conditions: overrun, transmitter state, FIFO full and data available.

Two error reporting modes are supported.

- **Character mode:** the flags shown are those of the character currently at the head, so they vanish as that character is popped.
- **Block mode:** the shown flags accumulate over every accepted character and stay set until software clears them with an error-reset command.

A receiver-reset command discards everything in one cycle.

Top module: `rx_err_fifo`

## Requirements
- R1: Status bit 3 equals `tx_empty`, bit 2 equals `tx_ready`, bit 1 is 1 exactly when the FIFO holds DEPTH (8) characters, and bit 0 is 1 exactly when it holds at least one.
- R2: Characters leave in the order they were accepted. `rd_data` shows the head character, or 0 when the FIFO is empty. A pop while empty has no effect.
- R3: With `blk_mode` low, status bits 7, 6 and 5 show the break, framing and parity flags stored with the head character, or 0 when the FIFO is empty. They change when that character is popped.
- R4: With `blk_mode` high, status bits 7..5 show the OR of the break/framing/parity flags of every character accepted since the last error reset or receiver reset. Pops do not affect them.
- R5: An `err_rst` cycle clears the overrun bit and the accumulated block flags. It also clears the flags of every character already stored, while leaving their data and the FIFO count unchanged. When an `err_rst` coincides with the setting of overrun or of an accumulated flag, the clear wins. A character pushed in that same cycle keeps its own flags in its FIFO entry.
- R6: A push while the FIFO holds DEPTH characters drops the character and sets status bit 4. The full condition is judged before any pop in the same cycle. A cycle with `ovr_in` high also sets bit 4. Bit 4 then stays set until an error reset or receiver reset.
- R7: A `rx_rst` cycle empties the FIFO and clears overrun and accumulated flags, and it overrides a push, `ovr_in` or any other command in the same cycle.
- R8: While `rst_n` is low the FIFO is emptied and all error state is cleared, so the status reads {4'b0000, tx_empty, tx_ready, 2'b00}.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| push | input | 1 | Receiver offers a character this cycle |
| push_data | input | DW | Received character |
| push_brk | input | 1 | Character was a line break |
| push_fe | input | 1 | Character had a framing error |
| push_pe | input | 1 | Character had a parity error |
| ovr_in | input | 1 | Overrun reported by the receiver |
| pop | input | 1 | Host removes the head character |
| err_rst | input | 1 | Error-reset command |
| rx_rst | input | 1 | Receiver-reset command |
| blk_mode | input | 1 | 1 = block error mode, 0 = character mode |
| tx_empty | input | 1 | Transmitter empty, passed to status bit 3 |
| tx_ready | input | 1 | Transmitter ready, passed to status bit 2 |
| rd_data | output | DW | Head character |
| status | output | 8 | Channel status word |

## Verification
The bench concentrates on the following corner cases.

- **Push and pop on a full FIFO.** A design that judged fullness after the pop would accept the character and never flag the overrun.
- **Draining in block mode.** A design that tied the sticky flags to the head would lose them once the FIFO emptied.
- **Error reset with characters still stored.** A design that cleared only the sticky register would show old parity or framing flags again on the next pop in character mode.
- **Receiver reset in the same cycle as a push and an overrun strobe.** A wrong priority would leave a character or a stale overrun behind.

// File: rtl/rx_err_fifo.sv
module rx_err_fifo #(
  parameter int DEPTH = 8,
  parameter int DW    = 8
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [DW-1:0] push_data,
  input  logic          push_brk,
  input  logic          push_fe,
  input  logic          push_pe,
  input  logic          ovr_in,
  input  logic          pop,
  input  logic          err_rst,
  input  logic          rx_rst,
  input  logic          blk_mode,
  input  logic          tx_empty,
  input  logic          tx_ready,
  output logic [DW-1:0] rd_data,
  output logic [7:0]    status
);
  localparam int AW = (DEPTH > 1) ? $clog2(DEPTH) : 1;
  localparam int CW = $clog2(DEPTH + 1);

  logic [DW-1:0] dmem [DEPTH];
  logic [2:0]    fmem [DEPTH];
  logic [AW-1:0] wp, rp;
  logic [CW-1:0] cnt;
  logic          ovr;
  logic [2:0]    sticky;

  wire full    = (cnt == CW'(DEPTH));
  wire empty   = (cnt == '0);
  wire do_push = push && !full && !rx_rst;
  wire do_pop  = pop && !empty && !rx_rst;
  wire [2:0] in_flags = {push_brk, push_fe, push_pe};

  function automatic logic [AW-1:0] nxt(input logic [AW-1:0] p);
    return (p == AW'(DEPTH - 1)) ? '0 : p + 1'b1;
  endfunction

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp <= '0; rp <= '0; cnt <= '0; ovr <= 1'b0; sticky <= '0;
    end else if (rx_rst) begin
      wp <= '0; rp <= '0; cnt <= '0; ovr <= 1'b0; sticky <= '0;
    end else begin
      if (do_push) wp <= nxt(wp);
      if (do_pop)  rp <= nxt(rp);
      cnt <= cnt + CW'(do_push) - CW'(do_pop);
      if (err_rst)                            ovr <= 1'b0;
      else if ((push && full) || ovr_in)      ovr <= 1'b1;
      if (err_rst)      sticky <= '0;
      else if (do_push) sticky <= sticky | in_flags;
    end
  end

  always_ff @(posedge clk) begin
    if (do_push) dmem[wp] <= push_data;
  end

  always_ff @(posedge clk) begin
    for (int i = 0; i < DEPTH; i++)
      if (err_rst) fmem[i] <= '0;
    if (do_push) fmem[wp] <= in_flags;
  end

  wire [2:0] head_flags = empty ? 3'b000 : fmem[rp];
  assign rd_data = empty ? '0 : dmem[rp];
  assign status  = {blk_mode ? sticky : head_flags, ovr, tx_empty, tx_ready, full, !empty};

  // R1
  count_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
    cnt <= CW'(DEPTH));

  // R6
  overrun_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (push && status[1] && !err_rst && !rx_rst) |=> status[4]);

  // R7
  rx_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rx_rst |=> (status[4] == 1'b0 && status[0] == 1'b0 && sticky == 3'b000 && rd_data == '0));

  // R5
  err_reset_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (err_rst && !rx_rst) |=> (!status[4] && sticky == 3'b000));

  // R2
  last_pop_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (cnt == CW'(1) && pop && !push) |=> (!status[0] && rd_data == '0));

  // R4
  sticky_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (!err_rst && !rx_rst) |=> ((sticky & $past(sticky)) == $past(sticky)));
endmodule

// File: tb/rx_err_fifo_test.sv
module rx_err_fifo_test;
  localparam int DEPTH = 8;

  logic clk = 1'b0;
  always #10 clk = ~clk;

  logic rst_n = 1'b0;
  logic push = 0, ovr_in = 0, pop = 0, err_rst = 0, rx_rst = 0;
  logic push_brk = 0, push_fe = 0, push_pe = 0;
  logic [7:0] push_data = '0;
  logic blk_mode = 0, tx_empty = 1, tx_ready = 1;
  logic [7:0] rd_data, status;

  int n_chk = 0, n_fail = 0;
  logic [10:0] mq[$];
  logic m_ovr = 0;
  logic [2:0] m_sticky = '0;
  bit live = 0;

  rx_err_fifo #(.DEPTH(DEPTH), .DW(8)) uut (
    .clk(clk), .rst_n(rst_n), .push(push), .push_data(push_data),
    .push_brk(push_brk), .push_fe(push_fe), .push_pe(push_pe),
    .ovr_in(ovr_in), .pop(pop), .err_rst(err_rst), .rx_rst(rx_rst),
    .blk_mode(blk_mode), .tx_empty(tx_empty), .tx_ready(tx_ready),
    .rd_data(rd_data), .status(status));

  task automatic chk(input string msg, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %0h expected %0h", msg, act, exp);
    end
  endtask

  task automatic tick(input logic p, input logic [7:0] d, input logic [2:0] fl,
                      input logic po, input logic er, input logic rr, input logic oi);
    logic full_m, accept;
    @(negedge clk);
    push = p; push_data = d; {push_brk, push_fe, push_pe} = fl;
    pop = po; err_rst = er; rx_rst = rr; ovr_in = oi;
    @(posedge clk);
    if (rr) begin
      mq.delete(); m_ovr = 0; m_sticky = '0;
    end else begin
      full_m = (mq.size() == DEPTH);
      accept = p && !full_m;
      if (po && mq.size() > 0) void'(mq.pop_front());
      if (er) foreach (mq[i]) mq[i][10:8] = 3'b000;
      if (accept) mq.push_back({fl, d});
      m_ovr    = er ? 1'b0 : (m_ovr || (p && full_m) || oi);
      m_sticky = er ? 3'b000 : (accept ? (m_sticky | fl) : m_sticky);
    end
    #1;
    push = 0; pop = 0; err_rst = 0; rx_rst = 0; ovr_in = 0;
    {push_brk, push_fe, push_pe} = 3'b000;
  endtask

  // scoreboard monitor
  always @(posedge clk) begin
    #5;
    if (live) begin
      chk("R2 head data", rd_data, mq.size() > 0 ? mq[0][7:0] : 8'h00);
      chk("R1 low status bits", status[3:0],
          {tx_empty, tx_ready, mq.size() == DEPTH, mq.size() != 0});
      chk("R6 overrun bit", status[4], m_ovr);
      if (blk_mode) chk("R4 sticky flags", status[7:5], m_sticky);
      else chk("R3 head flags", status[7:5], mq.size() > 0 ? mq[0][10:8] : 3'b000);
    end
  end

  initial begin
    repeat (100000) @(posedge clk);
    n_fail++;
    $display("FAIL watchdog: actual hung expected done");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    chk("R8 reset status", status, 8'h0C);
    rst_n = 1'b1;
    live = 1;

    // R3 character mode flags follow the head
    tick(1, 8'hA1, 3'b000, 0, 0, 0, 0);
    tick(1, 8'hB2, 3'b001, 0, 0, 0, 0);
    tick(1, 8'hC3, 3'b110, 0, 0, 0, 0);
    @(negedge clk); chk("R3 first head", {status[7:5], rd_data}, {3'b000, 8'hA1});
    tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R3 parity head", status[7:5], 3'b001);
    tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R3 break framing head", status[7:5], 3'b110);
    tick(0, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R2 pop on empty", {status, rd_data}, {8'h0C, 8'h00});

    // R1 / R6 fill, overflow, push+pop on full
    for (int i = 0; i < DEPTH; i++) tick(1, 8'h10 + 8'(i), 3'b000, 0, 0, 0, 0);
    @(negedge clk); chk("R1 full bit", status[1:0], 2'b11);
    tick(1, 8'hEE, 3'b000, 0, 0, 0, 0);
    @(negedge clk); chk("R6 overflow sets overrun", status[4], 1'b1);
    tick(1, 8'hEF, 3'b000, 1, 0, 0, 0);
    @(negedge clk); chk("R6 push+pop on full drops", {status[1], rd_data}, {1'b0, 8'h11});
    for (int i = 0; i < DEPTH - 1; i++) tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R6 overrun kept after drain", status[4:0], 5'b11100);
    tick(0, 0, 0, 0, 1, 0, 0);
    @(negedge clk); chk("R5 error reset clears overrun", status[4], 1'b0);
    tick(0, 0, 0, 0, 0, 0, 1);
    @(negedge clk); chk("R6 strobe sets overrun", status[4], 1'b1);
    tick(0, 0, 0, 0, 1, 0, 1);
    @(negedge clk); chk("R5 clear beats strobe", status[4], 1'b0);

    // R4 block mode
    @(negedge clk); blk_mode = 1;
    tick(1, 8'h41, 3'b001, 0, 0, 0, 0);
    tick(1, 8'h42, 3'b100, 0, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);
    tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R4 sticky after drain", {status[7:5], status[0]}, {3'b101, 1'b0});
    tick(0, 0, 0, 0, 1, 0, 0);
    @(negedge clk); chk("R5 error reset clears sticky", status[7:5], 3'b000);
    tick(1, 8'h43, 3'b010, 0, 1, 0, 0);
    @(negedge clk); chk("R5 clear beats same-cycle flag", status[7:5], 3'b000);
    @(negedge clk); blk_mode = 0;
    @(negedge clk); chk("R5 pushed char keeps own flags", {status[7:5], rd_data}, {3'b010, 8'h43});
    tick(0, 0, 0, 1, 0, 0, 0);

    // R5 error reset clears stored flags in character mode
    tick(1, 8'h55, 3'b010, 0, 0, 0, 0);
    tick(1, 8'h66, 3'b001, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 1, 0, 0);
    @(negedge clk); chk("R5 stored flags cleared", {status[7:5], status[0], rd_data}, {3'b000, 1'b1, 8'h55});
    tick(0, 0, 0, 1, 0, 0, 0);
    @(negedge clk); chk("R5 second char flags cleared", {status[7:5], rd_data}, {3'b000, 8'h66});
    tick(0, 0, 0, 1, 0, 0, 0);

    // R7 receiver reset
    tick(1, 8'h71, 3'b111, 0, 0, 0, 0);
    tick(1, 8'h72, 3'b010, 0, 0, 0, 1);
    tick(1, 8'h77, 3'b100, 1, 0, 1, 1);
    @(negedge clk); chk("R7 receiver reset empties", {status, rd_data}, {8'h0C, 8'h00});
    @(negedge clk); blk_mode = 1;
    tick(1, 8'h78, 3'b011, 0, 0, 0, 0);
    tick(0, 0, 0, 0, 0, 1, 0);
    @(negedge clk); chk("R7 reset clears block flags", status, 8'h0C);
    @(negedge clk); blk_mode = 0;

    // R1 transmitter pass-through
    @(negedge clk); tx_empty = 0; tx_ready = 1;
    @(negedge clk); chk("R1 tx bits 01", status[3:2], 2'b01);
    tx_empty = 1; tx_ready = 0;
    @(negedge clk); chk("R1 tx bits 10", status[3:2], 2'b10);
    tx_ready = 1;
    @(negedge clk);

    live = 0;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule